// File: doc/BRIEF.md
# Wavetable Voice End-of-Table Controller

This block holds the per-voice state of a bank of wavetable oscillators and decides, in one clock cycle, what happens to a voice when it reports an end event. An end event is either a wrap past the last entry of the voice's table or a zero sample read from the table. Depending on the voice's mode, the voice either stops by setting its halt bit, or, in free-running mode, keeps playing with its phase accumulator wrapped so that the fractional position past the end of the table is kept.

Voices are grouped in pairs whose indices differ only in bit 0. In swap mode, an ending voice starts its pair partner from the top of its table. An even voice also starts its partner when that partner is in swap mode. Each voice has an interrupt-enable bit. When that bit is set, the end event marks the voice as interrupt-pending and raises the shared interrupt line.

A load port writes a voice's control byte, accumulator, table size and resolution shift, and clears its pending flag. A combinational read port returns any voice's control byte, accumulator and pending flag. The block has no sequencer. Every event is resolved by a single decision path, which is an action classification (wrap or halt) plus a partner-restart decision, and is registered at the next clock edge.

Top module: `osc_end_ctrl`

## Requirements
- R1: After reset every voice has control byte 0x01 (halted, free-running mode), accumulator 0 and pending clear, and `irq` is low.
- R2: A zero-sample event (`evt_zero`=1) sets bit 0 (halt) of the voice's control byte in any mode and leaves its accumulator unchanged.
- R3: An end-of-table event (`evt_zero`=0) on a voice whose mode field, control bits [2:1], is one-shot (1), sync (2) or swap (3) sets bit 0 and leaves the accumulator unchanged.
- R4: An end-of-table event in free-running mode (mode 0) leaves the control byte unchanged. The new accumulator is found by shifting the accumulator right by the voice's resolution shift to give P, taking L = table size − 1, forming P − L when P > L, and shifting the result back left, truncated to 24 bits.
- R5: In the free-running wrap, P ≤ L gives an accumulator of 0, and P = L + 1 gives 1 << shift.
- R6: When the ending voice N is in swap mode, voice N XOR 1 has bit 0 of its control byte cleared, its other control bits kept, and its accumulator set to 0, in the same cycle.
- R7: An even ending voice whose partner (N+1) is in swap mode restarts that partner as in R6. An odd ending voice does not restart an even partner for being in swap mode.
- R8: When bit 3 of the ending voice's control byte is set, its pending flag is set and `irq` goes high. When bit 3 is clear, the pending flag stays clear.
- R9: A load writes the control byte, accumulator, table size and shift and clears the voice's pending flag. When `cfg_we` and `evt_valid` are both high in one cycle, the event is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | End event strobe, at most one per cycle |
| evt_osc | input | 5 | Index of the voice that ended |
| evt_zero | input | 1 | 1 = zero sample read, 0 = end of table |
| cfg_we | input | 1 | Load strobe |
| cfg_osc | input | 5 | Voice to load |
| cfg_ctrl | input | 8 | Control byte: bit 3 irq enable, bits 2:1 mode, bit 0 halt |
| cfg_acc | input | 24 | Phase accumulator value |
| cfg_tsize | input | 16 | Table size in entries |
| cfg_shift | input | 3 | Resolution shift, 0 to 7 |
| rd_osc | input | 5 | Voice selected on the read port |
| rd_ctrl | output | 8 | Control byte of the selected voice |
| rd_acc | output | 24 | Accumulator of the selected voice |
| rd_pend | output | 1 | Pending flag of the selected voice |
| irq | output | 1 | High while any voice is pending |

## Verification
The hardest situation to reach is the asymmetric partner restart. The ending voice must be in a halting mode, and its partner must already be halted in swap mode, so that the restart shows as a cleared bit 0 and a zeroed accumulator. The stimulus loads both voices of a pair through the load port, with a non-zero partner accumulator, and then fires the event once from the even side and once from the odd side. Wrap boundaries are reached by loading accumulators whose shifted value equals the limit, or exceeds it by one, and by loading a maximum accumulator with shift 7.

// File: rtl/osc_end_pkg.sv
package osc_end_pkg;

    typedef enum logic [1:0] {
        MODE_FREE    = 2'd0,
        MODE_ONESHOT = 2'd1,
        MODE_SYNC    = 2'd2,
        MODE_SWAP    = 2'd3
    } osc_mode_e;

    typedef enum logic {
        ACT_WRAP = 1'b0,
        ACT_HALT = 1'b1
    } end_action_e;

    localparam int CTRL_W    = 8;
    localparam int HALT_BIT  = 0;
    localparam int IRQEN_BIT = 3;

endpackage

// File: rtl/osc_phase_wrap.sv
module osc_phase_wrap #(
    parameter int ACC_W   = 24,
    parameter int TSZ_W   = 16,
    parameter int SHIFT_W = 3
) (
    input  logic [ACC_W-1:0]   acc_in,
    input  logic [TSZ_W-1:0]   tsize,
    input  logic [SHIFT_W-1:0] shift,
    output logic [ACC_W-1:0]   acc_out
);
    logic [TSZ_W-1:0] limit;
    logic [ACC_W-1:0] phase;
    logic [ACC_W-1:0] limit_ext;
    logic [ACC_W-1:0] remain;

    always_comb begin
        limit     = tsize - TSZ_W'(1);
        limit_ext = ACC_W'(limit);
        phase     = acc_in >> shift;
        if (phase > limit_ext) begin
            remain = phase - limit_ext;
        end else begin
            remain = '0;
        end
        acc_out = remain << shift;
    end
endmodule

// File: rtl/osc_end_decide.sv
module osc_end_decide
    import osc_end_pkg::*;
#(
    parameter int ACC_W   = 24,
    parameter int TSZ_W   = 16,
    parameter int SHIFT_W = 3
) (
    input  logic [CTRL_W-1:0]  self_ctrl,
    input  logic [ACC_W-1:0]   self_acc,
    input  logic [TSZ_W-1:0]   self_tsize,
    input  logic [SHIFT_W-1:0] self_shift,
    input  logic [1:0]         part_mode,
    input  logic               evt_zero,
    input  logic               evt_odd,
    output logic [CTRL_W-1:0]  next_ctrl,
    output logic [ACC_W-1:0]   next_acc,
    output logic               restart_part,
    output logic               pend_set
);
    osc_mode_e        self_mode_e;
    osc_mode_e        part_mode_e;
    end_action_e      action;
    logic [ACC_W-1:0] wrapped_acc;

    osc_phase_wrap #(
        .ACC_W  (ACC_W),
        .TSZ_W  (TSZ_W),
        .SHIFT_W(SHIFT_W)
    ) u_wrap (
        .acc_in (self_acc),
        .tsize  (self_tsize),
        .shift  (self_shift),
        .acc_out(wrapped_acc)
    );

    always_comb begin
        self_mode_e = osc_mode_e'(self_ctrl[2:1]);
        part_mode_e = osc_mode_e'(part_mode);
        if (evt_zero || (self_mode_e != MODE_FREE)) begin
            action = ACT_HALT;
        end else begin
            action = ACT_WRAP;
        end
    end

    always_comb begin
        next_ctrl = self_ctrl;
        next_acc  = self_acc;
        unique case (action)
            ACT_HALT: next_ctrl[HALT_BIT] = 1'b1;
            ACT_WRAP: next_acc = wrapped_acc;
        endcase
        restart_part = (self_mode_e == MODE_SWAP) ||
                       ((part_mode_e == MODE_SWAP) && !evt_odd);
        pend_set     = self_ctrl[IRQEN_BIT];
    end
endmodule

// File: rtl/osc_slot.sv
module osc_slot
    import osc_end_pkg::*;
#(
    parameter int ACC_W   = 24,
    parameter int TSZ_W   = 16,
    parameter int SHIFT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_sel,
    input  logic [CTRL_W-1:0]  load_ctrl,
    input  logic [ACC_W-1:0]   load_acc,
    input  logic [TSZ_W-1:0]   load_tsize,
    input  logic [SHIFT_W-1:0] load_shift,
    input  logic               self_sel,
    input  logic [CTRL_W-1:0]  self_ctrl,
    input  logic [ACC_W-1:0]   self_acc,
    input  logic               self_pend,
    input  logic               part_sel,
    output logic [CTRL_W-1:0]  ctrl_q,
    output logic [ACC_W-1:0]   acc_q,
    output logic [TSZ_W-1:0]   tsize_q,
    output logic [SHIFT_W-1:0] shift_q,
    output logic               pend_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= CTRL_W'(1);
            acc_q   <= '0;
            tsize_q <= '0;
            shift_q <= '0;
            pend_q  <= 1'b0;
        end else if (load_sel) begin
            ctrl_q  <= load_ctrl;
            acc_q   <= load_acc;
            tsize_q <= load_tsize;
            shift_q <= load_shift;
            pend_q  <= 1'b0;
        end else if (self_sel) begin
            ctrl_q <= self_ctrl;
            acc_q  <= self_acc;
            if (self_pend) begin
                pend_q <= 1'b1;
            end
        end else if (part_sel) begin
            ctrl_q[HALT_BIT] <= 1'b0;
            acc_q            <= '0;
        end
    end
endmodule

// File: rtl/osc_end_ctrl.sv
module osc_end_ctrl
    import osc_end_pkg::*;
#(
    parameter int NUM_OSC = 32,
    parameter int ACC_W   = 24,
    parameter int TSZ_W   = 16,
    parameter int SHIFT_W = 3,
    localparam int OSC_W  = $clog2(NUM_OSC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt_valid,
    input  logic [OSC_W-1:0]   evt_osc,
    input  logic               evt_zero,
    input  logic               cfg_we,
    input  logic [OSC_W-1:0]   cfg_osc,
    input  logic [CTRL_W-1:0]  cfg_ctrl,
    input  logic [ACC_W-1:0]   cfg_acc,
    input  logic [TSZ_W-1:0]   cfg_tsize,
    input  logic [SHIFT_W-1:0] cfg_shift,
    input  logic [OSC_W-1:0]   rd_osc,
    output logic [CTRL_W-1:0]  rd_ctrl,
    output logic [ACC_W-1:0]   rd_acc,
    output logic               rd_pend,
    output logic               irq
);
    logic [NUM_OSC-1:0][CTRL_W-1:0]  slot_ctrl;
    logic [NUM_OSC-1:0][ACC_W-1:0]   slot_acc;
    logic [NUM_OSC-1:0][TSZ_W-1:0]   slot_tsize;
    logic [NUM_OSC-1:0][SHIFT_W-1:0] slot_shift;
    logic [NUM_OSC-1:0]              slot_pend;

    logic               evt_go;
    logic [OSC_W-1:0]   part_osc;
    logic [CTRL_W-1:0]  next_ctrl;
    logic [ACC_W-1:0]   next_acc;
    logic               restart_part;
    logic               pend_set;
    logic [CTRL_W-1:0]  part_ctrl;

    assign evt_go    = evt_valid && !cfg_we;
    assign part_osc  = evt_osc ^ OSC_W'(1);
    assign part_ctrl = slot_ctrl[part_osc];

    osc_end_decide #(
        .ACC_W  (ACC_W),
        .TSZ_W  (TSZ_W),
        .SHIFT_W(SHIFT_W)
    ) u_decide (
        .self_ctrl   (slot_ctrl[evt_osc]),
        .self_acc    (slot_acc[evt_osc]),
        .self_tsize  (slot_tsize[evt_osc]),
        .self_shift  (slot_shift[evt_osc]),
        .part_mode   (part_ctrl[2:1]),
        .evt_zero    (evt_zero),
        .evt_odd     (evt_osc[0]),
        .next_ctrl   (next_ctrl),
        .next_acc    (next_acc),
        .restart_part(restart_part),
        .pend_set    (pend_set)
    );

    for (genvar i = 0; i < NUM_OSC; i++) begin : g_slot
        localparam logic [OSC_W-1:0] IDX = OSC_W'(i);
        logic load_sel;
        logic self_sel;
        logic part_sel;

        assign load_sel = cfg_we && (cfg_osc == IDX);
        assign self_sel = evt_go && (evt_osc == IDX);
        assign part_sel = evt_go && restart_part && (part_osc == IDX);

        osc_slot #(
            .ACC_W  (ACC_W),
            .TSZ_W  (TSZ_W),
            .SHIFT_W(SHIFT_W)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_sel  (load_sel),
            .load_ctrl (cfg_ctrl),
            .load_acc  (cfg_acc),
            .load_tsize(cfg_tsize),
            .load_shift(cfg_shift),
            .self_sel  (self_sel),
            .self_ctrl (next_ctrl),
            .self_acc  (next_acc),
            .self_pend (pend_set),
            .part_sel  (part_sel),
            .ctrl_q    (slot_ctrl[i]),
            .acc_q     (slot_acc[i]),
            .tsize_q   (slot_tsize[i]),
            .shift_q   (slot_shift[i]),
            .pend_q    (slot_pend[i])
        );
    end

    assign rd_ctrl = slot_ctrl[rd_osc];
    assign rd_acc  = slot_acc[rd_osc];
    assign rd_pend = slot_pend[rd_osc];
    assign irq     = |slot_pend;
endmodule

// File: rtl/osc_end_ctrl_chk.sv
module osc_end_ctrl_chk #(
    parameter int NUM_OSC = 32,
    parameter int ACC_W   = 24,
    parameter int OSC_W   = 5
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           evt_go,
    input logic [OSC_W-1:0]               evt_osc,
    input logic                           evt_zero,
    input logic                           cfg_we,
    input logic [OSC_W-1:0]               cfg_osc,
    input logic [7:0]                     cfg_ctrl,
    input logic [NUM_OSC-1:0][7:0]        slot_ctrl,
    input logic [NUM_OSC-1:0][ACC_W-1:0]  slot_acc,
    input logic [NUM_OSC-1:0]             slot_pend,
    input logic                           irq
);
    logic [OSC_W-1:0] osc_q;
    logic [OSC_W-1:0] cfg_osc_q;
    logic [7:0]       cfg_ctrl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            osc_q      <= '0;
            cfg_osc_q  <= '0;
            cfg_ctrl_q <= '0;
        end else begin
            osc_q      <= evt_osc;
            cfg_osc_q  <= cfg_osc;
            cfg_ctrl_q <= cfg_ctrl;
        end
    end

    // R2
    a_r2_zero_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_go && evt_zero) |=> slot_ctrl[osc_q][0]);

    // R3
    a_r3_mode_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_go && (slot_ctrl[evt_osc][2:1] != 2'd0)) |=> slot_ctrl[osc_q][0]);

    // R4
    a_r4_free_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_go && !evt_zero && (slot_ctrl[evt_osc][2:0] == 3'd0))
        |=> !slot_ctrl[osc_q][0]);

    // R6
    a_r6_swap_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_go && (slot_ctrl[evt_osc][2:1] == 2'd3))
        |=> (!slot_ctrl[osc_q ^ OSC_W'(1)][0] && (slot_acc[osc_q ^ OSC_W'(1)] == '0)));

    // R8
    a_r8_irq_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_go && slot_ctrl[evt_osc][3]) |=> (irq && slot_pend[osc_q]));

    // R9
    a_r9_load_applies: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> ((slot_ctrl[cfg_osc_q] == cfg_ctrl_q) && !slot_pend[cfg_osc_q]));
endmodule

bind osc_end_ctrl osc_end_ctrl_chk #(
    .NUM_OSC(NUM_OSC),
    .ACC_W  (ACC_W),
    .OSC_W  (OSC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_go   (evt_go),
    .evt_osc  (evt_osc),
    .evt_zero (evt_zero),
    .cfg_we   (cfg_we),
    .cfg_osc  (cfg_osc),
    .cfg_ctrl (cfg_ctrl),
    .slot_ctrl(slot_ctrl),
    .slot_acc (slot_acc),
    .slot_pend(slot_pend),
    .irq      (irq)
);

// File: tb/tb_osc_end_ctrl.sv
module tb_osc_end_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic [4:0]  evt_osc = '0;
    logic        evt_zero = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_osc = '0;
    logic [7:0]  cfg_ctrl = '0;
    logic [23:0] cfg_acc = '0;
    logic [15:0] cfg_tsize = '0;
    logic [2:0]  cfg_shift = '0;
    logic [4:0]  rd_osc = '0;
    logic [7:0]  rd_ctrl;
    logic [23:0] rd_acc;
    logic        rd_pend;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    osc_end_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .evt_valid(evt_valid), .evt_osc(evt_osc), .evt_zero(evt_zero),
        .cfg_we(cfg_we), .cfg_osc(cfg_osc), .cfg_ctrl(cfg_ctrl),
        .cfg_acc(cfg_acc), .cfg_tsize(cfg_tsize), .cfg_shift(cfg_shift),
        .rd_osc(rd_osc), .rd_ctrl(rd_ctrl), .rd_acc(rd_acc),
        .rd_pend(rd_pend), .irq(irq)
    );

    function automatic logic [23:0] wrap_ref(input logic [23:0] a,
                                             input logic [15:0] ts,
                                             input int sh);
        longint p = longint'(a) >> sh;
        longint l = longint'(ts) - 1;
        longint r = (p > l) ? (p - l) : 0;
        return 24'((r << sh) & 64'hFFFFFF);
    endfunction

    task automatic check_val(input string req, input string what,
                             input longint got, input longint exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, got, exp);
        end
    endtask

    task automatic check_osc(input string req, input int osc,
                             input logic [7:0] e_ctrl, input logic [23:0] e_acc);
        rd_osc = 5'(osc);
        #1;
        check_val(req, $sformatf("ctrl[%0d]", osc), longint'(rd_ctrl), longint'(e_ctrl));
        check_val(req, $sformatf("acc[%0d]", osc), longint'(rd_acc), longint'(e_acc));
    endtask

    task automatic load(input int osc, input logic [7:0] c, input logic [23:0] a,
                        input logic [15:0] ts, input logic [2:0] sh);
        @(negedge clk);
        cfg_osc = 5'(osc); cfg_ctrl = c; cfg_acc = a; cfg_tsize = ts; cfg_shift = sh;
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic fire(input int osc, input logic zero);
        @(negedge clk);
        evt_osc = 5'(osc); evt_zero = zero; evt_valid = 1'b1;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic t_reset();
        check_osc("R1", 0, 8'h01, 24'h0);
        check_osc("R1", 31, 8'h01, 24'h0);
        check_val("R1", "pend[31]", longint'(rd_pend), 0);
        check_val("R1", "irq", longint'(irq), 0);
    endtask

    task automatic t_zero_sample();
        load(3, 8'h00, 24'h000123, 16'h0100, 3'd0);
        fire(3, 1'b1);
        check_osc("R2", 3, 8'h01, 24'h000123);
    endtask

    task automatic t_halting_modes();
        load(5, 8'h02, 24'h000500, 16'h0100, 3'd1);
        fire(5, 1'b0);
        check_osc("R3", 5, 8'h03, 24'h000500);
        load(6, 8'h04, 24'h000600, 16'h0100, 3'd1);
        fire(6, 1'b0);
        check_osc("R3", 6, 8'h05, 24'h000600);
    endtask

    task automatic t_free_wrap();
        load(7, 8'h00, 24'h001234, 16'h0100, 3'd2);
        fire(7, 1'b0);
        check_osc("R4", 7, 8'h00, wrap_ref(24'h001234, 16'h0100, 2));
        check_osc("R4", 7, 8'h00, 24'h000E38);
        load(9, 8'h00, 24'hFFFFFF, 16'h8000, 3'd7);
        fire(9, 1'b0);
        check_osc("R4", 9, 8'h00, 24'hC00000);
    endtask

    task automatic t_wrap_bounds();
        load(8, 8'h00, 24'h0000FF, 16'h0100, 3'd0);
        fire(8, 1'b0);
        check_osc("R5", 8, 8'h00, 24'h000000);
        load(8, 8'h00, 24'h000400, 16'h0100, 3'd2);
        fire(8, 1'b0);
        check_osc("R5", 8, 8'h00, 24'h000004);
    endtask

    task automatic t_swap_pair();
        load(11, 8'h03, 24'h000777, 16'h0100, 3'd0);
        load(10, 8'h06, 24'h000100, 16'h0100, 3'd0);
        fire(10, 1'b0);
        check_osc("R6", 10, 8'h07, 24'h000100);
        check_osc("R6", 11, 8'h02, 24'h000000);
        load(12, 8'h05, 24'h000055, 16'h0100, 3'd0);
        load(13, 8'h06, 24'h000200, 16'h0100, 3'd0);
        fire(13, 1'b0);
        check_osc("R6", 12, 8'h04, 24'h000000);
    endtask

    task automatic t_partner_swap();
        load(15, 8'h07, 24'h000099, 16'h0100, 3'd0);
        load(14, 8'h02, 24'h000010, 16'h0100, 3'd0);
        fire(14, 1'b0);
        check_osc("R7", 14, 8'h03, 24'h000010);
        check_osc("R7", 15, 8'h06, 24'h000000);
        load(16, 8'h07, 24'h000099, 16'h0100, 3'd0);
        load(17, 8'h02, 24'h000010, 16'h0100, 3'd0);
        fire(17, 1'b0);
        check_osc("R7", 16, 8'h07, 24'h000099);
    endtask

    task automatic t_irq();
        load(21, 8'h02, 24'h0, 16'h0100, 3'd0);
        fire(21, 1'b0);
        rd_osc = 5'd21; #1;
        check_val("R8", "pend[21]", longint'(rd_pend), 0);
        check_val("R8", "irq", longint'(irq), 0);
        load(20, 8'h0A, 24'h0, 16'h0100, 3'd0);
        fire(20, 1'b0);
        rd_osc = 5'd20; #1;
        check_val("R8", "pend[20]", longint'(rd_pend), 1);
        check_val("R8", "irq", longint'(irq), 1);
        load(20, 8'h02, 24'h0, 16'h0100, 3'd0);
        rd_osc = 5'd20; #1;
        check_val("R9", "pend[20]", longint'(rd_pend), 0);
        check_val("R9", "irq", longint'(irq), 0);
    endtask

    task automatic t_collision();
        load(23, 8'h02, 24'h000033, 16'h0100, 3'd0);
        @(negedge clk);
        cfg_osc = 5'd22; cfg_ctrl = 8'h04; cfg_acc = 24'h000010;
        cfg_tsize = 16'h0100; cfg_shift = 3'd0; cfg_we = 1'b1;
        evt_osc = 5'd23; evt_zero = 1'b0; evt_valid = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; evt_valid = 1'b0;
        check_osc("R9", 22, 8'h04, 24'h000010);
        check_osc("R9", 23, 8'h02, 24'h000033);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero_sample();
        t_halting_modes();
        t_free_wrap();
        t_wrap_bounds();
        t_swap_pair();
        t_partner_swap();
        t_irq();
        t_collision();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule